// File: doc/BRIEF.md
# Enabled Eight-Step Single-Bit-Change Sequencer

This block is a synchronous Moore machine that walks a three-bit output through a fixed cycle of eight codes. Neighbouring codes differ in exactly one bit. The cycle runs 000, 010, 011, 001, 101, 111, 110, 100 and then returns to 000. This is a custom ordering, not the usual reflected binary count.

A single enable input decides whether the machine moves one step at a rising clock edge. When the enable is low, the output keeps its value. A synchronous active-high reset puts the machine back at the first code.

The outputs come straight from flip-flops, so a change on the enable cannot cause a glitch on them. A parameter selects between two state encodings:
- The state register holds the output code itself.
- The state register holds a binary step index, and a separate registered output is loaded with the decoded code.

Both encodings give identical outputs cycle for cycle.

Top module: `gray8_stepper`

## Requirements
- R1: When `rst` is 1 at a rising edge of `clk`, `{code_hi,code_mid,code_lo}` becomes 000 after that edge, whatever the value of `step_en`.
- R2: When `rst` is 0 and `step_en` is 1 at a rising edge, the output moves to the next code in the order 000, 010, 011, 001, 101, 111, 110, 100. `code_hi` is the most significant bit and `code_lo` the least significant bit.
- R3: Whenever the output changes, the old and new values differ in exactly one bit.
- R4: When `rst` is 0 and `step_en` is 0 at a rising edge, the output keeps its current value.
- R5: From code 100, an enabled edge returns the output to 000, which is a change in one bit only.
- R6: The output changes only at rising edges of `clk`. Toggling `step_en` between edges leaves the output unchanged.
- R7: With `STATE_STYLE` = 1 (binary index state), the output matches the `STATE_STYLE` = 0 (code-valued state) build on every cycle for the same inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset to code 000 |
| step_en | input | 1 | Advance one step at the next rising edge when 1 |
| code_hi | output | 1 | Most significant code bit |
| code_mid | output | 1 | Middle code bit |
| code_lo | output | 1 | Least significant code bit |

## Verification
The embedded properties assume that `rst` and `step_en` are settled at every rising edge. They also assume that the cycle right after a reset is judged only against the reset rule, not against the stepping rule. The bench changes every input a fixed time after the rising edge, well clear of the next one. Its mid-cycle toggling of `step_en` is confined to the space between edges, and it always ends on a defined level before the edge.

// File: rtl/gseq_pkg.sv
package gseq_pkg;

   localparam int CODE_W = 3;
   localparam int STEPS  = 8;

   typedef logic [CODE_W-1:0] code_t;

   typedef enum int {
      STYLE_CODE  = 0,
      STYLE_INDEX = 1
   } style_e;

   // code held at a given position of the cycle
   function automatic code_t code_at(input logic [CODE_W-1:0] idx);
      code_t c;
      case (idx)
         3'd0:    c = 3'b000;
         3'd1:    c = 3'b010;
         3'd2:    c = 3'b011;
         3'd3:    c = 3'b001;
         3'd4:    c = 3'b101;
         3'd5:    c = 3'b111;
         3'd6:    c = 3'b110;
         default: c = 3'b100;
      endcase
      return c;
   endfunction

   // successor of a code, written directly on code values
   function automatic code_t code_after(input code_t cur);
      code_t n;
      case (cur)
         3'b000:  n = 3'b010;
         3'b010:  n = 3'b011;
         3'b011:  n = 3'b001;
         3'b001:  n = 3'b101;
         3'b101:  n = 3'b111;
         3'b111:  n = 3'b110;
         3'b110:  n = 3'b100;
         default: n = 3'b000;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/gseq_reg.sv
module gseq_reg #(
   parameter int                 WIDTH     = 3,
   parameter logic [WIDTH-1:0]   RST_VALUE = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   initial begin
      if (WIDTH < 1) $error("gseq_reg: WIDTH must be positive");
   end

   always_ff @(posedge clk) begin
      if (rst) q <= RST_VALUE;
      else     q <= d;
   end

endmodule

// File: rtl/gseq_advance.sv
module gseq_advance
   import gseq_pkg::*;
#(
   parameter int STATE_STYLE = 0,
   parameter int ST_W        = CODE_W
) (
   input  logic            step_en,
   input  logic [ST_W-1:0] cur_state,
   output logic [ST_W-1:0] nxt_state,
   output code_t           nxt_code
);

   localparam int LAST_IDX = STEPS - 1;

   initial begin
      if (STATE_STYLE != STYLE_CODE && STATE_STYLE != STYLE_INDEX)
         $error("gseq_advance: STATE_STYLE must be 0 or 1");
      if (ST_W != CODE_W)
         $error("gseq_advance: state width must equal code width");
   end

   generate
      if (STATE_STYLE == STYLE_CODE) begin : g_code_state
         always_comb begin
            nxt_state = step_en ? code_after(cur_state) : cur_state;
            nxt_code  = nxt_state;
         end
      end else begin : g_index_state
         always_comb begin
            if (!step_en)
               nxt_state = cur_state;
            else if (cur_state == ST_W'(LAST_IDX))
               nxt_state = '0;
            else
               nxt_state = cur_state + 1'b1;
            nxt_code = code_at(nxt_state);
         end
      end
   endgenerate

endmodule

// File: rtl/gray8_stepper.sv
module gray8_stepper
   import gseq_pkg::*;
#(
   parameter int STATE_STYLE = 0
) (
   input  logic clk,
   input  logic rst,
   input  logic step_en,
   output logic code_hi,
   output logic code_mid,
   output logic code_lo
);

   localparam int ST_W = CODE_W;

   initial begin
      if (STEPS != 8) $error("gray8_stepper: cycle length must be 8");
      if (STATE_STYLE != STYLE_CODE && STATE_STYLE != STYLE_INDEX)
         $error("gray8_stepper: unsupported STATE_STYLE");
   end

   logic [ST_W-1:0] state_q;
   logic [ST_W-1:0] state_d;
   code_t           code_d;
   code_t           code_q;

   gseq_advance #(
      .STATE_STYLE (STATE_STYLE),
      .ST_W        (ST_W)
   ) u_adv (
      .step_en   (step_en),
      .cur_state (state_q),
      .nxt_state (state_d),
      .nxt_code  (code_d)
   );

   gseq_reg #(.WIDTH(ST_W), .RST_VALUE('0)) u_state (
      .clk (clk),
      .rst (rst),
      .d   (state_d),
      .q   (state_q)
   );

   generate
      if (STATE_STYLE == STYLE_CODE) begin : g_out_direct
         assign code_q = state_q;
      end else begin : g_out_reg
         gseq_reg #(.WIDTH(CODE_W), .RST_VALUE(3'b000)) u_out (
            .clk (clk),
            .rst (rst),
            .d   (code_d),
            .q   (code_q)
         );
      end
   endgenerate

   assign {code_hi, code_mid, code_lo} = code_q;

   AST_RESET_ZERO: assert property (@(posedge clk) rst |=> code_q == 3'b000); // R1

   AST_ORDER_STEP: assert property (@(posedge clk) disable iff (rst)
      (step_en && !$past(rst)) |=> code_q == code_after($past(code_q))); // R2

   AST_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && code_q != $past(code_q)) |-> $countones(code_q ^ $past(code_q)) == 1); // R3

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      !step_en |=> $stable(code_q)); // R4

   AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
      (step_en && code_q == 3'b100) |=> code_q == 3'b000); // R5

endmodule

// File: tb/test_gray8_stepper.sv
`timescale 1ns/100ps
module test_gray8_stepper;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic step_en = 1'b0;
   logic a_hi, a_mid, a_lo;
   logic b_hi, b_mid, b_lo;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   int ref_idx = 0;
   logic [2:0] prev_out = 3'b000;
   logic [2:0] order [8];
   logic [15:0] lfsr = 16'hACE1;

   always #2.5 clk = ~clk;

   gray8_stepper #(.STATE_STYLE(0)) i_gray8_stepper (
      .clk(clk), .rst(rst), .step_en(step_en),
      .code_hi(a_hi), .code_mid(a_mid), .code_lo(a_lo));

   gray8_stepper #(.STATE_STYLE(1)) i_gray8_stepper_idx (
      .clk(clk), .rst(rst), .step_en(step_en),
      .code_hi(b_hi), .code_mid(b_mid), .code_lo(b_lo));

   function automatic logic [2:0] outa();
      return {a_hi, a_mid, a_lo};
   endfunction

   function automatic logic [2:0] outb();
      return {b_hi, b_mid, b_lo};
   endfunction

   task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   // one clock: drive, pass the edge, update model, compare
   task automatic cycle(input logic r, input logic e, input string req);
      rst = r;
      step_en = e;
      @(posedge clk);
      #2;
      if (r) ref_idx = 0;
      else if (e) ref_idx = (ref_idx + 1) % 8;
      check(req, outa(), order[ref_idx]);
      if (outa() !== prev_out) begin
         checks++;
         if ($countones(outa() ^ prev_out) != 1 && !r) begin
            fails++;
            $display("FAIL R3: actual %b -> %b expected one-bit change", prev_out, outa());
         end
      end
      check("R7", outb(), outa());
      prev_out = outa();
   endtask

   task automatic t_reset();
      cycle(1'b1, 1'b1, "R1");
      cycle(1'b1, 1'b0, "R1");
      cycle(1'b0, 1'b0, "R4");
   endtask

   task automatic t_walk();
      for (int i = 0; i < 24; i++) cycle(1'b0, 1'b1, (ref_idx == 7) ? "R5" : "R2");
   endtask

   task automatic t_hold();
      for (int i = 0; i < 3; i++) cycle(1'b0, 1'b1, "R2");
      for (int i = 0; i < 5; i++) cycle(1'b0, 1'b0, "R4");
      for (int i = 0; i < 4; i++) cycle(1'b0, 1'b1, (ref_idx == 7) ? "R5" : "R2");
      cycle(1'b0, 1'b0, "R4");
   endtask

   task automatic t_random();
      for (int i = 0; i < 60; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         cycle(1'b0, lfsr[0], lfsr[0] ? "R2" : "R4");
      end
   endtask

   task automatic t_midcycle();
      logic [2:0] held;
      cycle(1'b0, 1'b1, "R2");
      held = outa();
      for (int i = 0; i < 4; i++) begin
         step_en = ~step_en;
         #0.4;
         check("R6", outa(), held);
      end
      step_en = 1'b0;
      #0.3;
      check("R6", outa(), held);
      cycle(1'b0, 1'b0, "R4");
   endtask

   task automatic t_reset_midseq();
      for (int i = 0; i < 5; i++) cycle(1'b0, 1'b1, "R2");
      cycle(1'b1, 1'b1, "R1");
      cycle(1'b0, 1'b1, "R2");
   endtask

   initial begin
      order[0] = 3'b000; order[1] = 3'b010; order[2] = 3'b011; order[3] = 3'b001;
      order[4] = 3'b101; order[5] = 3'b111; order[6] = 3'b110; order[7] = 3'b100;
      #1;
      t_reset();
      t_walk();
      t_hold();
      t_random();
      t_midcycle();
      t_reset_midseq();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      #20000;
      if (!done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

endmodule